// File: doc/BRIEF.md
# Multi-Mode Sixteen-Entry Lookup Element

This block is a single-bit lookup element built around one 16-bit storage word. A static mode input, held steady outside reset, decides how that word is used. As a truth table it realises any Boolean function of the four select inputs. As a synchronous RAM it stores one bit per address. As a shift register it moves its contents up by one place on each enabled clock, with a tap that the select inputs choose.

The initial contents are taken from a parallel configuration input while reset is held. The addressed bit is always presented combinationally on `bit_out`. The highest entry is always presented on `chain_out`, so several elements can be chained into a longer shift register.

Top module: `multimode_lut`

## Requirements
- R1: At every rising clock edge while `rst_n` is low, the stored word is replaced by `cfg_init`.
- R2: `bit_out` equals stored entry `sel` combinationally. `sel` is an unsigned index, so entry 0 is all select inputs low and entry 15 is all high. For example, word 16'h8000 gives a 4-input AND and word 16'hFFFE gives a 4-input OR.
- R3: With `mode_sel` = 2'b00 (function), the stored word never changes, whatever `wr_en` and `shift_en` do.
- R4: With `mode_sel` = 2'b01 (RAM), a rising edge with `wr_en` high writes `wr_data` into entry `sel`. All other entries keep their value.
- R5: In RAM mode a written value is readable on `bit_out` right after the writing edge, with no further clock.
- R6: In RAM mode `shift_en` has no effect, and an edge with `wr_en` low leaves the word unchanged.
- R7: With `mode_sel` = 2'b10 (shift), a rising edge with `shift_en` high moves entry i into entry i+1 and loads `shift_in` into entry 0. `bit_out` then acts as a variable-length tap.
- R8: In shift mode `wr_en` has no effect, and an edge with `shift_en` low leaves the word unchanged.
- R9: `chain_out` always equals entry 15.
- R10: `mode_sel` = 2'b11 behaves as function mode: the word is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads the configuration word |
| mode_sel | input | 2 | Static mode: 00 function, 01 RAM, 10 shift, 11 function |
| cfg_init | input | 16 | Initial contents loaded during reset |
| sel | input | 4 | Address / function inputs |
| wr_data | input | 1 | RAM write data |
| wr_en | input | 1 | RAM write enable |
| shift_in | input | 1 | Serial input into entry 0 |
| shift_en | input | 1 | Shift enable |
| bit_out | output | 1 | Addressed entry |
| chain_out | output | 1 | Entry 15, serial output |

## Verification
The hardest case to reach is an enable that the current mode must ignore while other logic could still act on it. Examples are a write strobe during a shift step, a shift strobe during a RAM write, and both strobes in the frozen modes. To reach these, the stimulus asserts both enables together in every mode. After each such edge it sweeps all sixteen select values, so that any stray update to any entry shows up on `bit_out`. The unused mode code 2'b11 is loaded through reset and given the same treatment.

// File: rtl/lut_pkg.sv
package lut_pkg;
  typedef enum logic [1:0] {
    LM_FUNC  = 2'b00,
    LM_RAM   = 2'b01,
    LM_SHIFT = 2'b10,
    LM_SPARE = 2'b11
  } lut_mode_e;
endpackage

// File: rtl/lut_mode_decode.sv
module lut_mode_decode
  import lut_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       wr_en,
  input  logic       shift_en,
  output logic       ram_we,
  output logic       shift_step
);
  lut_mode_e mode;

  always_comb begin
    mode       = lut_mode_e'(mode_sel);
    ram_we     = 1'b0;
    shift_step = 1'b0;
    case (mode)
      LM_RAM:   ram_we     = wr_en;
      LM_SHIFT: shift_step = shift_en;
      default: begin
        ram_we     = 1'b0;
        shift_step = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lut_cells.sv
module lut_cells #(
  parameter int DEPTH = 16,
  parameter int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] cfg_init,
  input  logic             ram_we,
  input  logic             shift_step,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr_data,
  input  logic             shift_in,
  output logic [DEPTH-1:0] cells
);
  logic [DEPTH-1:0] cells_next;

  function automatic logic [DEPTH-1:0] shift_once(input logic [DEPTH-1:0] v, input logic b);
    return {v[DEPTH-2:0], b};
  endfunction

  function automatic logic [DEPTH-1:0] write_one(input logic [DEPTH-1:0] v,
                                                 input logic [SEL_W-1:0] idx,
                                                 input logic d);
    logic [DEPTH-1:0] r;
    r      = v;
    r[idx] = d;
    return r;
  endfunction

  always_comb begin
    cells_next = cells;
    if (ram_we)
      cells_next = write_one(cells, sel, wr_data);
    else if (shift_step)
      cells_next = shift_once(cells, shift_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cells <= cfg_init;
    else        cells <= cells_next;
  end
endmodule

// File: rtl/lut_tap.sv
module lut_tap #(
  parameter int DEPTH = 16,
  parameter int SEL_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cells,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_out,
  output logic             chain_out
);
  always_comb begin
    bit_out   = cells[sel];
    chain_out = cells[DEPTH-1];
  end
endmodule

// File: rtl/multimode_lut.sv
module multimode_lut
  import lut_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [DEPTH-1:0] cfg_init,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr_data,
  input  logic             wr_en,
  input  logic             shift_in,
  input  logic             shift_en,
  output logic             bit_out,
  output logic             chain_out
);
  logic             ram_write_ev;
  logic             shift_ev;
  logic [DEPTH-1:0] cells;

  lut_mode_decode u_dec (
    .mode_sel  (mode_sel),
    .wr_en     (wr_en),
    .shift_en  (shift_en),
    .ram_we    (ram_write_ev),
    .shift_step(shift_ev)
  );

  lut_cells #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_cells (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_init  (cfg_init),
    .ram_we    (ram_write_ev),
    .shift_step(shift_ev),
    .sel       (sel),
    .wr_data   (wr_data),
    .shift_in  (shift_in),
    .cells     (cells)
  );

  lut_tap #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_tap (
    .cells    (cells),
    .sel      (sel),
    .bit_out  (bit_out),
    .chain_out(chain_out)
  );

  // Frozen modes (function and spare code) keep the word.
  assert_frozen_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == LM_FUNC || mode_sel == LM_SPARE) |=> $stable(cells));

  // The decoder never requests a write and a shift together.
  assert_single_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_write_ev && shift_ev));

  assert_ram_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_write_ev |=> cells[$past(sel)] == $past(wr_data));

  assert_ram_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == LM_RAM && !wr_en) |=> $stable(cells));

  assert_shift_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> (cells[DEPTH-1:1] == $past(cells[DEPTH-2:0]) && cells[0] == $past(shift_in)));

  assert_chain_tap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out == bit_out || sel != SEL_W'(DEPTH-1));
endmodule

// File: tb/tb_multimode_lut.sv
`timescale 1ns/100ps
module tb_multimode_lut;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [15:0] cfg_init = 16'h0000;
  logic [3:0]  sel = 4'd0;
  logic        wr_data = 1'b0, wr_en = 1'b0, shift_in = 1'b0, shift_en = 1'b0;
  logic        bit_out, chain_out;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] model;

  always #2 clk = ~clk;

  multimode_lut dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cfg_init(cfg_init),
    .sel(sel), .wr_data(wr_data), .wr_en(wr_en), .shift_in(shift_in),
    .shift_en(shift_en), .bit_out(bit_out), .chain_out(chain_out)
  );

  // {cfg word, select, expected bit}: R2 truth-table vectors
  localparam logic [20:0] VEC [10] = '{
    {16'h8000, 4'd15, 1'b1}, {16'h8000, 4'd14, 1'b0},
    {16'hFFFE, 4'd0,  1'b0}, {16'hFFFE, 4'd9,  1'b1},
    {16'h6996, 4'd7,  1'b1}, {16'h6996, 4'd3,  1'b0},
    {16'h6996, 4'd1,  1'b1}, {16'h8001, 4'd0,  1'b1},
    {16'h0002, 4'd1,  1'b1}, {16'h0002, 4'd2,  1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (sel=%0d)", req, act, exp, sel);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [15:0] cfg);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; cfg_init = cfg;
    wr_en = 1'b0; shift_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cfg_init = ~cfg;
    model = cfg;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 16; i++) begin
      sel = 4'(i);
      #0.1;
      chk(req, bit_out, model[i]);
    end
    chk("R9", chain_out, model[15]);
  endtask

  // One clock edge with the given strobes; model follows the requirements.
  task automatic cyc(input logic we, input logic wd, input logic se,
                     input logic si, input logic [3:0] s);
    @(negedge clk);
    wr_en = we; wr_data = wd; shift_en = se; shift_in = si; sel = s;
    @(posedge clk);
    #0.2;
    wr_en = 1'b0; shift_en = 1'b0;
    if (mode_sel == 2'b01 && we) model[s] = wd;
    else if (mode_sel == 2'b10 && se) model = {model[14:0], si};
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // Reset state (R1)
    do_reset(2'b00, 16'hA5C3);
    sweep("R1");

    // Table walk (R2)
    for (int v = 0; v < 10; v++) begin
      do_reset(2'b00, VEC[v][20:5]);
      sel = VEC[v][4:1];
      #0.1;
      chk("R2", bit_out, VEC[v][0]);
    end

    // Function mode frozen (R3)
    do_reset(2'b00, 16'h6996);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd2);
    sweep("R3");

    // Spare mode code frozen (R10)
    do_reset(2'b11, 16'h3C0F);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'd4);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 4'd0);
    sweep("R10");

    // RAM mode (R4, R5, R6)
    do_reset(2'b01, 16'h00F0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'd3);
    sel = 4'd3; #0.1; chk("R5", bit_out, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd5);
    sel = 4'd5; #0.1; chk("R5", bit_out, 1'b0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 4'd15);
    chk("R9", chain_out, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    sweep("R4");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd7);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'd8);
    sweep("R6");

    // Shift mode (R7, R8)
    do_reset(2'b10, 16'h8001);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
    sweep("R7");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 4'd6);
    sweep("R7");
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'd2);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'd1);
    sweep("R7");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd9);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd4);
    sweep("R8");
    for (int k = 0; k < 16; k++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
    sweep("R7");
    chk("R9", chain_out, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule